// File: doc/BRIEF.md
# Capture Timer

A 16-bit up-counter peripheral that timestamps external events. It can advance on every system clock, once every twelve system clocks, or once per falling edge of an external count pin. A falling edge on a separate capture pin copies the live count into a capture register and sets a sticky capture flag. When the counter wraps past its top value it sets a sticky overflow flag. An interrupt output is raised while either flag is set and interrupts are enabled.

Software drives the block through a small synchronous register port: a control register, the live count and the capture value. Both external pins are asynchronous. Each one passes through a two-flop synchronizer followed by a falling-edge detector. Counting and capture take place only while the mode-select bit and the run bit are both set.

Top module: `evt_capture_timer`

## Requirements
- R1: After reset the control register, the count, the capture register and `irq` all read 0.
- R2: When the count source is the system clock undivided (control bit1=0, bit4=0) and bit0 (mode select) and bit2 (run) are both 1, the count rises by exactly one on every clock.
- R3: With control bit4=1 (divide by twelve) and bit1=0, the count rises by exactly one every twelve clocks.
- R4: With control bit1=1, the count rises by one for each falling edge on `cnt_pin`. Rising edges and constant levels have no effect.
- R5: While bit0 or bit2 is 0, the count holds its value except when software writes to it.
- R6: When control bit3 (capture enable) is 1 and counting is active, a falling edge on `cap_pin` copies the count into the capture register (address 2, read-only) and sets the capture flag (control bit6).
- R7: While bit3 is 0, edges on `cap_pin` leave the capture register and the capture flag unchanged.
- R8: An increment from 0xFFFF gives 0x0000 and sets the overflow flag (control bit7).
- R9: `irq` is 1 exactly when control bit5 (interrupt enable) is 1 and at least one flag is set.
- R10: The flags are sticky. Writing 0 to a flag bit of the control register (address 0) clears it, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R11: When a capture edge and an increment fall in the same cycle, the capture register receives the count from before that increment.
- R12: A write to address 1 loads the count, and this takes priority over an increment. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 count, 2 capture |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| cnt_pin | input | 1 | External count pin, asynchronous |
| cap_pin | input | 1 | External capture pin, asynchronous |
| irq | output | 1 | Combined interrupt |

## Verification
The count source is tried three ways, each over a fixed window: the undivided clock, the divided clock and pin pulses. The count difference over each window separates the three sources and shows whether the prescaler period is exactly twelve. Capture is tried with a frozen count, with capture disabled, and with a capture edge and a count edge arriving together. These three cases separate a correct copy from an ignored event and from a copy taken after the increment. A wrap test started just below 0xFFFF checks that the overflow flag, the interrupt gate and the write-0 flag clear all behave as specified.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_COUNT = 2'd1,
    A_CAPT  = 2'd2,
    A_NONE  = 2'd3
  } reg_addr_t;

  // Control register layout, bit0 at the bottom.
  typedef struct packed {
    logic flag_ovf; // bit7
    logic flag_cap; // bit6
    logic irq_en;   // bit5
    logic div12;    // bit4
    logic cap_en;   // bit3
    logic run;      // bit2
    logic ext_cnt;  // bit1
    logic cap_sel;  // bit0
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int BIT_FCAP = 6;
  localparam int BIT_FOVF = 7;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_fall_det.sv
module tmr_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;
  logic [PW-1:0] div_d;
  logic          at_last;

  always_comb begin
    at_last = (div_q == LAST);
    div_d   = at_last ? '0 : div_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = at_last;
endmodule

// File: rtl/tmr_cnt_cap.sv
module tmr_cnt_cap #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_on,
  input  logic         cap_en,
  input  logic         tick,
  input  logic         cap_ev,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         clr_cap,
  input  logic         clr_ovf,
  output logic [W-1:0] count_o,
  output logic [W-1:0] capt_o,
  output logic         flag_cap_o,
  output logic         flag_ovf_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] count_q, count_d;
  logic [W-1:0] capt_q,  capt_d;
  logic         fcap_q,  fcap_d;
  logic         fovf_q,  fovf_d;
  logic         inc, wrap, take;

  always_comb begin
    inc  = mode_on & tick & ~ld_en;
    wrap = inc & (count_q == TOP);
    take = mode_on & cap_en & cap_ev;

    count_d = count_q;
    if (ld_en)    count_d = ld_val;
    else if (inc) count_d = count_q + W'(1);

    // pre-increment value is copied
    capt_d = take ? count_q : capt_q;

    fcap_d = take | (fcap_q & ~clr_cap);
    fovf_d = wrap | (fovf_q & ~clr_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      capt_q  <= '0;
      fcap_q  <= 1'b0;
      fovf_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      capt_q  <= capt_d;
      fcap_q  <= fcap_d;
      fovf_q  <= fovf_d;
    end
  end

  assign count_o    = count_q;
  assign capt_o     = capt_q;
  assign flag_cap_o = fcap_q;
  assign flag_ovf_o = fovf_q;
endmodule

// File: rtl/evt_capture_timer.sv
module evt_capture_timer
  import tmr_pkg::*;
#(
  parameter int PRE_DIV   = 12,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cnt_pin,
  input  logic              cap_pin,
  output logic              irq
);
  logic             rst_sync_n;
  logic             cnt_fall_w, cap_fall_w, pre_tick_w, tick_w;
  logic             mode_on_w, cap_en_w, irq_en_w;
  logic             ctrl_wr, count_wr, clr_cap_w, clr_ovf_w;
  logic [CNT_W-1:0] count_w, capt_w;
  logic             flag_cap_w, flag_ovf_w;
  ctrl_t            ctrl_q, ctrl_d, ctrl_rd;
  reg_addr_t        addr_dec;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tmr_fall_det #(.STAGES(SYNC_STG)) u_cnt_edge (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(cnt_pin), .fall_o(cnt_fall_w)
  );

  tmr_fall_det #(.STAGES(SYNC_STG)) u_cap_edge (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(cap_pin), .fall_o(cap_fall_w)
  );

  tmr_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .tick_o(pre_tick_w)
  );

  always_comb begin
    addr_dec  = reg_addr_t'(reg_addr);
    ctrl_wr   = reg_wr & (addr_dec == A_CTRL);
    count_wr  = reg_wr & (addr_dec == A_COUNT);
    clr_cap_w = ctrl_wr & ~reg_wdata[BIT_FCAP];
    clr_ovf_w = ctrl_wr & ~reg_wdata[BIT_FOVF];

    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d          = ctrl_t'(reg_wdata[CTRL_W-1:0]);
      ctrl_d.flag_cap = 1'b0;
      ctrl_d.flag_ovf = 1'b0;
    end

    mode_on_w = ctrl_q.cap_sel & ctrl_q.run;
    cap_en_w  = ctrl_q.cap_en;
    irq_en_w  = ctrl_q.irq_en;

    if (ctrl_q.ext_cnt)    tick_w = cnt_fall_w;
    else if (ctrl_q.div12) tick_w = pre_tick_w;
    else                   tick_w = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctrl_q <= '0;
    else             ctrl_q <= ctrl_d;
  end

  tmr_cnt_cap #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n),
    .mode_on(mode_on_w), .cap_en(cap_en_w),
    .tick(tick_w), .cap_ev(cap_fall_w),
    .ld_en(count_wr), .ld_val(reg_wdata[CNT_W-1:0]),
    .clr_cap(clr_cap_w), .clr_ovf(clr_ovf_w),
    .count_o(count_w), .capt_o(capt_w),
    .flag_cap_o(flag_cap_w), .flag_ovf_o(flag_ovf_w)
  );

  always_comb begin
    ctrl_rd          = ctrl_q;
    ctrl_rd.flag_cap = flag_cap_w;
    ctrl_rd.flag_ovf = flag_ovf_w;
    case (addr_dec)
      A_CTRL:  reg_rdata = DATA_W'(ctrl_rd);
      A_COUNT: reg_rdata = DATA_W'(count_w);
      A_CAPT:  reg_rdata = DATA_W'(capt_w);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = irq_en_w & (flag_cap_w | flag_ovf_w);
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_on,
  input logic         cap_en,
  input logic         irq_en,
  input logic         tick,
  input logic         cap_ev,
  input logic         ld_en,
  input logic         clr_cap,
  input logic         clr_ovf,
  input logic [W-1:0] count,
  input logic [W-1:0] capt,
  input logic         flag_cap,
  input logic         flag_ovf,
  input logic         irq
);
  localparam logic [W-1:0] TOP = '1;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && tick && !ld_en && count != TOP) |=> (count == $past(count) + W'(1)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_on && !ld_en) |=> $stable(count));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && cap_en && cap_ev) |=> (capt == $past(count) && flag_cap));

  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_on && cap_en && cap_ev) |=> $stable(capt));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && tick && !ld_en && count == TOP) |=> (count == '0 && flag_ovf));

  p_irq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && (flag_cap || flag_ovf)) |-> irq);

  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en || (!flag_cap && !flag_ovf)) |-> !irq);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovf && !clr_ovf) |=> flag_ovf);

  p_sticky_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cap && !clr_cap) |=> flag_cap);
endmodule

bind evt_capture_timer tmr_checker #(.W(tmr_pkg::CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .mode_on(mode_on_w), .cap_en(cap_en_w), .irq_en(irq_en_w),
  .tick(tick_w), .cap_ev(cap_fall_w), .ld_en(count_wr),
  .clr_cap(clr_cap_w), .clr_ovf(clr_ovf_w),
  .count(count_w), .capt(capt_w),
  .flag_cap(flag_cap_w), .flag_ovf(flag_ovf_w), .irq(irq)
);

// File: tb/evt_capture_timer_tb_top.sv
`timescale 1ns/1ps
module evt_capture_timer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        cnt_pin;
  logic        cap_pin;
  logic        irq;

  int checks;
  int errors;
  bit done;

  typedef struct {
    bit          is_irq;
    logic [1:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  item_t cur;

  evt_capture_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cnt_pin(cnt_pin), .cap_pin(cap_pin), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // monitor: pops expected items and compares with outputs
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      logic [15:0] act;
      cur = sb_q.pop_front();
      act = cur.is_irq ? {15'd0, irq} : reg_rdata;
      checks++;
      if (act !== cur.exp) begin
        errors++;
        $display("FAIL %s act=%h exp=%h", cur.tag, act, cur.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic chk_reg(input logic [1:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #0.5;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.addr = 2'd0; it.exp = {15'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #0.5;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    @(posedge clk); #1;
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_cnt(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_pin = 1'b0; idle(4);
      cnt_pin = 1'b1; idle(4);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] base;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    cnt_pin = 1'b1; cap_pin = 1'b1;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    chk_reg(2'd0, 16'h0000, "R1 ctrl");
    chk_reg(2'd1, 16'h0000, "R1 count");
    chk_reg(2'd2, 16'h0000, "R1 capture");
    chk_irq(1'b0, "R1 irq");

    // R12 load, unused address
    wr(2'd1, 16'h0100);
    chk_reg(2'd1, 16'h0100, "R12 load");
    chk_reg(2'd3, 16'h0000, "R12 unused addr");

    // R5 hold while stopped
    idle(10);
    chk_reg(2'd1, 16'h0100, "R5 hold idle");
    wr(2'd0, 16'h0004);
    idle(10);
    chk_reg(2'd1, 16'h0100, "R5 hold no mode select");

    // R2 undivided clock
    wr(2'd0, 16'h0005);
    peek(2'd1, base);
    repeat (49) @(posedge clk);
    chk_reg(2'd1, base + 16'd50, "R2 one per clock");
    wr(2'd0, 16'h0000);

    // R3 divide by twelve
    wr(2'd0, 16'h0015);
    peek(2'd1, base);
    repeat (119) @(posedge clk);
    chk_reg(2'd1, base + 16'd10, "R3 one per twelve");
    wr(2'd0, 16'h0000);

    // R4 external count
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0007);
    idle(4);
    pulse_cnt(6);
    chk_reg(2'd1, 16'h0006, "R4 six falling edges");
    chk_reg(2'd0, 16'h0007, "R4 ctrl readback");

    // R6 capture with frozen count
    wr(2'd1, 16'h1234);
    wr(2'd0, 16'h000F);
    cap_pin = 1'b0; idle(5);
    chk_reg(2'd2, 16'h1234, "R6 capture value");
    chk_reg(2'd0, 16'h004F, "R6 capture flag");
    chk_irq(1'b0, "R9 irq masked");
    cap_pin = 1'b1; idle(4);

    // R9 / R10 interrupt gate and flag clear
    wr(2'd0, 16'h006F);
    chk_irq(1'b1, "R9 irq on capture flag");
    chk_reg(2'd0, 16'h006F, "R10 write one keeps flag");
    wr(2'd0, 16'h002F);
    chk_reg(2'd0, 16'h002F, "R10 write zero clears flag");
    chk_irq(1'b0, "R9 irq after clear");

    // R7 capture disabled
    wr(2'd0, 16'h0007);
    wr(2'd1, 16'h5678);
    cap_pin = 1'b0; idle(5);
    chk_reg(2'd2, 16'h1234, "R7 capture ignored");
    chk_reg(2'd0, 16'h0007, "R7 flag stays clear");
    cap_pin = 1'b1; idle(4);

    // R11 simultaneous capture and increment
    wr(2'd1, 16'h00FF);
    wr(2'd0, 16'h000F);
    cnt_pin = 1'b0; cap_pin = 1'b0; idle(5);
    chk_reg(2'd2, 16'h00FF, "R11 pre-increment capture");
    chk_reg(2'd1, 16'h0100, "R11 count advanced");
    cnt_pin = 1'b1; cap_pin = 1'b1; idle(4);
    wr(2'd0, 16'h0000);

    // R8 wrap
    wr(2'd1, 16'hFFFD);
    wr(2'd0, 16'h0025);
    repeat (10) @(posedge clk);
    wr(2'd0, 16'h00A0);
    chk_reg(2'd1, 16'h0009, "R8 count after wrap");
    chk_reg(2'd0, 16'h00A0, "R8 overflow flag");
    chk_irq(1'b1, "R9 irq on overflow");
    wr(2'd0, 16'h0020);
    chk_reg(2'd0, 16'h0020, "R10 overflow cleared");
    chk_irq(1'b0, "R9 irq cleared");

    @(negedge clk); #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule